// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block is a hardware state machine that takes an SD memory card from power-up to the transfer state without software help. After a start strobe it issues a fixed series of commands on a command-issue interface. Each command has an index, an argument and a response kind. The block takes each 48-bit or 136-bit response back, along with a timeout flag from the link layer. It checks every response and ends with either a done flag or an error flag with a reason code.

The sequence runs in this order:
- a software reset;
- the interface-condition check;
- a polled operating-condition handshake that is retried up to a limit, with a delay between polls;
- capture of the card identity;
- assignment of the card address and capture of the card-specific data;
- card selection;
- a block-length setting for standard-capacity cards only;
- a switch to a 4-bit data bus.

The CMD line framing, the CRC and all data-line transfers are handled by neighbouring blocks.

Top module: `sd_ident_seq`

## Requirements
- R1: After start, commands are issued in the order CMD0 (arg 0), CMD8 (arg 0x1AA), {CMD55 (arg 0), ACMD41 (arg 0x50FF8000)} repeated, CMD2 (arg 0), CMD3 (arg 0), CMD9, CMD7, optional CMD16 (arg 512), CMD55, ACMD6 (arg 2).
  - Response kind encoding: 0 = none, 1 = 48-bit, 2 = 136-bit.
  - CMD0 is kind 0, CMD2 and CMD9 are kind 2, and every other command is kind 1.
  - CMD0 advances without waiting for a response.
  - At most one command is outstanding at a time.
- R2: If CMD8 gets no response, the sequence ends with error code 1 (unsupported).
- R3: If the CMD8 response word is not exactly 0x1AA, the sequence ends with error code 2 (no usable card).
- R4: If an ACMD41 response lacks any bit of mask 0x00FF8000, the sequence ends with error code 2.
- R5: The CMD55/ACMD41 pair is repeated until ACMD41 response bit 31 is 1. If MAX_POLLS ACMD41 responses all have bit 31 at 0, the sequence ends with error code 3 (I/O), and exactly MAX_POLLS ACMD41 commands have been issued.
- R6: After a not-ready ACMD41 response, at least POLL_GAP idle cycles pass before the next CMD55 is issued.
- R7: `card_ccs` takes bit 30 of the final ACMD41 response. CMD16 is issued only when that bit is 0.
- R8: The card address is bits 31:16 of the CMD3 response. It appears on `card_rca`, and it is used as argument {rca,16'h0} for CMD9, CMD7 and the final CMD55.
- R9: In the CMD3 response, status bits 15, 14 and 13 are remapped to card-status bits 23, 22 and 19. For CMD55, CMD7, CMD16 and ACMD6, bits 23, 22 or 19 of the response are checked directly. Any of these bits set ends the sequence with error code 3.
- R10: A timeout on any command other than CMD8 ends the sequence with error code 3. A timeout is either the timeout flag or RSP_WAIT cycles without a response.
- R11: `done` and `err` are never both set, and each stays set until the next start. A start strobe while busy is ignored. Error code 0 is paired with `done`.
- R12: `card_cid` and `card_csd` hold the CMD2 and CMD9 responses, and `card_ocr` holds the final ACMD41 response.
- R13: After reset, `busy`, `done`, `err` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, accepted when not busy |
| cmd_valid | output | 1 | One-cycle command issue |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_kind | output | 2 | Response kind: 0 none, 1 48-bit, 2 136-bit |
| rsp_valid | input | 1 | Response available |
| rsp_timeout | input | 1 | Link layer saw no response |
| rsp_data | input | 128 | Response content (48-bit responses in bits 31:0) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Card reached transfer state |
| err | output | 1 | Sequence failed |
| err_code | output | 2 | 0 none, 1 unsupported, 2 no usable card, 3 I/O |
| card_rca | output | 16 | Card address |
| card_ccs | output | 1 | Capacity-status bit |
| card_ocr | output | 32 | Final operating-condition response |
| card_cid | output | 128 | Card identity register |
| card_csd | output | 128 | Card-specific data register |

## Verification
The bench builds the block with MAX_POLLS=5, POLL_GAP=3 and RSP_WAIT=12. With these values, poll exhaustion, the inter-poll delay and the silent-CMD8 timeout all take a few dozen cycles instead of thousands. A behavioural card model answers each command. A queue of expected commands, built from each scenario's card settings, is compared with every issued command. Separate scenarios cover:
- a standard-capacity card and a high-capacity card;
- a bad CMD8 echo and a missing CMD8 echo;
- a voltage window rejection and a card that never becomes ready;
- a remapped CMD3 status error, an illegal-command bit on CMD7 and a flagged timeout on CMD9;
- a start strobe sent mid-run.

// File: rtl/sd_ident_pkg.sv
// Shared types and constants for the SD card identification sequencer.
// Assumes the response kind encoding is shared with the link layer.
package sd_ident_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_UNSUP  = 2'd1,
        ERR_NOCARD = 2'd2,
        ERR_IO     = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        CHK_NONE,
        CHK_R1,
        CHK_R6
    } chk_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RESET,
        S_IFCOND,
        S_POLL_APP,
        S_POLL_OP,
        S_POLL_GAP,
        S_GET_CID,
        S_GET_RCA,
        S_GET_CSD,
        S_SELECT,
        S_BLKLEN,
        S_BUS_APP,
        S_BUS_WIDTH,
        S_DONE,
        S_FAIL
    } step_e;

    localparam logic [31:0] IF_COND_ARG = 32'h0000_01AA;
    localparam logic [31:0] OP_COND_ARG = 32'h50FF_8000;
    localparam logic [31:0] VWIN_MASK   = 32'h00FF_8000;
    localparam logic [31:0] BLOCK_BYTES = 32'd512;
    localparam logic [31:0] BUS4_ARG    = 32'd2;

endpackage

// File: rtl/sd_step_decode.sv
// Maps the current sequencer step to the command it issues.
// Assumes: only command steps set is_cmd; the card address is zero until
// it is captured from the CMD3 response.
module sd_step_decode
    import sd_ident_pkg::*;
(
    input  step_e       step,
    input  logic [15:0] rca,
    output logic        is_cmd,
    output logic [5:0]  index,
    output logic [31:0] arg,
    output rsp_kind_e   kind,
    output chk_e        chk
);

    // Command table: index, argument, response kind and status check per step.
    always_comb begin
        is_cmd = 1'b1;
        index  = 6'd0;
        arg    = 32'd0;
        kind   = RSP_SHORT;
        chk    = CHK_NONE;
        case (step)
            S_RESET: begin
                index = 6'd0;
                kind  = RSP_NONE;
            end
            S_IFCOND: begin
                index = 6'd8;
                arg   = IF_COND_ARG;
            end
            S_POLL_APP: begin
                index = 6'd55;
                chk   = CHK_R1;
            end
            S_POLL_OP: begin
                index = 6'd41;
                arg   = OP_COND_ARG;
            end
            S_GET_CID: begin
                index = 6'd2;
                kind  = RSP_LONG;
            end
            S_GET_RCA: begin
                index = 6'd3;
                chk   = CHK_R6;
            end
            S_GET_CSD: begin
                index = 6'd9;
                arg   = {rca, 16'h0};
                kind  = RSP_LONG;
            end
            S_SELECT: begin
                index = 6'd7;
                arg   = {rca, 16'h0};
                chk   = CHK_R1;
            end
            S_BLKLEN: begin
                index = 6'd16;
                arg   = BLOCK_BYTES;
                chk   = CHK_R1;
            end
            S_BUS_APP: begin
                index = 6'd55;
                arg   = {rca, 16'h0};
                chk   = CHK_R1;
            end
            S_BUS_WIDTH: begin
                index = 6'd6;
                arg   = BUS4_ARG;
                chk   = CHK_R1;
            end
            default: begin
                is_cmd = 1'b0;
                kind   = RSP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/sd_status_check.sv
// Flags error bits in a 48-bit response's card status word.
// Assumes: an R6-style word carries status bits 23, 22 and 19 in bits 15, 14
// and 13; it is remapped to the full card-status layout before the test.
module sd_status_check
    import sd_ident_pkg::*;
(
    input  logic [31:0] word,
    input  chk_e        chk,
    output logic        bad
);

    logic [31:0] status;

    // Normalise the status layout, then test error, illegal and CRC bits.
    always_comb begin
        status = word;
        if (chk == CHK_R6) begin
            status       = {16'h0, 3'b000, word[12:0]};
            status[23]   = word[15];
            status[22]   = word[14];
            status[19]   = word[13];
        end
        bad = (chk != CHK_NONE) && (status[23] || status[22] || status[19]);
    end

endmodule

// File: rtl/sd_rsp_waiter.sv
// Tracks one outstanding command and bounds its wait for a response.
// Assumes: a new issue never arrives while a response is pending.
module sd_rsp_waiter #(
    parameter int WAIT_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic rsp_valid,
    input  logic rsp_timeout,
    output logic pending,
    output logic got,
    output logic lapsed
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign got    = pending && rsp_valid;
    assign lapsed = pending && !rsp_valid &&
                    (rsp_timeout || cnt == CNT_W'(WAIT_CYCLES - 1));

    // Pending flag and elapsed-cycle counter for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (issue) begin
            pending <= 1'b1;
            cnt     <= '0;
        end else if (got || lapsed) begin
            pending <= 1'b0;
        end else if (pending) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r10_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (cnt < CNT_W'(WAIT_CYCLES)));

    a_r1_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !pending);

endmodule

// File: rtl/sd_gap_timer.sv
// Down-counter that spaces consecutive operating-condition polls.
// Assumes GAP_CYCLES >= 1; done is high once the count reaches zero.
module sd_gap_timer #(
    parameter int GAP_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CNT_W = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign done = (cnt == '0);

    // Reload on a retry, count down while the sequencer waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(GAP_CYCLES);
        end else if (run && !done) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/sd_ident_seq.sv
// SD card identification sequencer: walks a card from power-up to the
// transfer state through a fixed command series and reports done or an error.
// Assumes: the link layer pulses rsp_valid or rsp_timeout once per command
// with a response; 48-bit response content sits in rsp_data[31:0].
module sd_ident_seq
    import sd_ident_pkg::*;
#(
    parameter int RSP_WAIT  = 4096,
    parameter int MAX_POLLS = 1000,
    parameter int POLL_GAP  = 2000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic         cmd_valid,
    output logic [5:0]   cmd_index,
    output logic [31:0]  cmd_arg,
    output logic [1:0]   cmd_kind,
    input  logic         rsp_valid,
    input  logic         rsp_timeout,
    input  logic [127:0] rsp_data,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [1:0]   err_code,
    output logic [15:0]  card_rca,
    output logic         card_ccs,
    output logic [31:0]  card_ocr,
    output logic [127:0] card_cid,
    output logic [127:0] card_csd
);

    localparam int TRY_W = $clog2(MAX_POLLS + 1);

    step_e            step_q;
    err_e             code_q;
    logic [TRY_W-1:0] try_q;
    logic [15:0]      rca_q;
    logic             ccs_q;
    logic [31:0]      ocr_q;
    logic [127:0]     cid_q;
    logic [127:0]     csd_q;

    logic        dec_is_cmd;
    logic [5:0]  dec_idx;
    logic [31:0] dec_arg;
    rsp_kind_e   dec_kind;
    chk_e        dec_chk;

    logic        pending, got, lapsed, issue;
    logic        st_bad, vw_ok, poll_retry, gap_done;
    logic [31:0] word;

    sd_step_decode u_dec (
        .step   (step_q),
        .rca    (rca_q),
        .is_cmd (dec_is_cmd),
        .index  (dec_idx),
        .arg    (dec_arg),
        .kind   (dec_kind),
        .chk    (dec_chk)
    );

    assign cmd_valid = dec_is_cmd && !pending;
    assign cmd_index = dec_idx;
    assign cmd_arg   = dec_arg;
    assign cmd_kind  = dec_kind;
    assign issue     = cmd_valid && (dec_kind != RSP_NONE);

    sd_rsp_waiter #(.WAIT_CYCLES(RSP_WAIT)) u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .rsp_valid   (rsp_valid),
        .rsp_timeout (rsp_timeout),
        .pending     (pending),
        .got         (got),
        .lapsed      (lapsed)
    );

    assign word = rsp_data[31:0];

    sd_status_check u_chk (
        .word (word),
        .chk  (dec_chk),
        .bad  (st_bad)
    );

    assign vw_ok      = (word & VWIN_MASK) == VWIN_MASK;
    assign poll_retry = got && (step_q == S_POLL_OP) && vw_ok && !word[31] &&
                        (try_q != TRY_W'(MAX_POLLS - 1));

    sd_gap_timer #(.GAP_CYCLES(POLL_GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (poll_retry),
        .run   (step_q == S_POLL_GAP),
        .done  (gap_done)
    );

    // Sequencer: advances on responses, records card data and failure reasons.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= S_IDLE;
            code_q <= ERR_NONE;
            try_q  <= '0;
            rca_q  <= '0;
            ccs_q  <= 1'b0;
            ocr_q  <= '0;
            cid_q  <= '0;
            csd_q  <= '0;
        end else begin
            case (step_q)
                S_IDLE, S_DONE, S_FAIL: begin
                    if (start) begin
                        step_q <= S_RESET;
                        code_q <= ERR_NONE;
                        try_q  <= '0;
                    end
                end
                S_POLL_GAP: begin
                    if (gap_done) step_q <= S_POLL_APP;
                end
                default: begin
                    if (cmd_valid && dec_kind == RSP_NONE) begin
                        step_q <= S_IFCOND;
                    end else if (lapsed) begin
                        step_q <= S_FAIL;
                        code_q <= (step_q == S_IFCOND) ? ERR_UNSUP : ERR_IO;
                    end else if (got && st_bad) begin
                        step_q <= S_FAIL;
                        code_q <= ERR_IO;
                    end else if (got) begin
                        case (step_q)
                            S_IFCOND: begin
                                if (word == IF_COND_ARG) begin
                                    step_q <= S_POLL_APP;
                                end else begin
                                    step_q <= S_FAIL;
                                    code_q <= ERR_NOCARD;
                                end
                            end
                            S_POLL_APP: step_q <= S_POLL_OP;
                            S_POLL_OP: begin
                                if (!vw_ok) begin
                                    step_q <= S_FAIL;
                                    code_q <= ERR_NOCARD;
                                end else begin
                                    ocr_q <= word;
                                    if (word[31]) begin
                                        ccs_q  <= word[30];
                                        step_q <= S_GET_CID;
                                    end else if (try_q == TRY_W'(MAX_POLLS - 1)) begin
                                        step_q <= S_FAIL;
                                        code_q <= ERR_IO;
                                    end else begin
                                        try_q  <= try_q + 1'b1;
                                        step_q <= S_POLL_GAP;
                                    end
                                end
                            end
                            S_GET_CID: begin
                                cid_q  <= rsp_data;
                                step_q <= S_GET_RCA;
                            end
                            S_GET_RCA: begin
                                rca_q  <= word[31:16];
                                step_q <= S_GET_CSD;
                            end
                            S_GET_CSD: begin
                                csd_q  <= rsp_data;
                                step_q <= S_SELECT;
                            end
                            S_SELECT:    step_q <= ccs_q ? S_BUS_APP : S_BLKLEN;
                            S_BLKLEN:    step_q <= S_BUS_APP;
                            S_BUS_APP:   step_q <= S_BUS_WIDTH;
                            S_BUS_WIDTH: step_q <= S_DONE;
                            default:     step_q <= S_FAIL;
                        endcase
                    end
                end
            endcase
        end
    end

    assign busy     = (step_q != S_IDLE) && (step_q != S_DONE) && (step_q != S_FAIL);
    assign done     = (step_q == S_DONE);
    assign err      = (step_q == S_FAIL);
    assign err_code = code_q;
    assign card_rca = rca_q;
    assign card_ccs = ccs_q;
    assign card_ocr = ocr_q;
    assign card_cid = cid_q;
    assign card_csd = csd_q;

    a_r11_err_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != ERR_NONE));

    a_r11_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == ERR_NONE));

    a_r11_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(card_rca)));

    a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !cmd_valid);

    a_r5_poll_limit: assert property (@(posedge clk) disable iff (!rst_n)
        try_q < TRY_W'(MAX_POLLS));

    a_r7_blklen_sdsc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_index == 6'd16) |-> !card_ccs);

endmodule

// File: tb/tb_sd_ident_seq.sv
module tb_sd_ident_seq;

    localparam int CLK_PERIOD = 10;
    localparam int T_WAIT  = 12;
    localparam int T_POLLS = 5;
    localparam int T_GAP   = 3;
    localparam logic [15:0]  RCA = 16'hB3C5;
    localparam logic [127:0] CID = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] CSD = 128'h400E_0032_5B59_0000_76B2_7F80_0A40_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmd_valid;
    logic [5:0]   cmd_index;
    logic [31:0]  cmd_arg;
    logic [1:0]   cmd_kind;
    logic         rsp_valid = 1'b0;
    logic         rsp_timeout = 1'b0;
    logic [127:0] rsp_data = '0;
    logic         busy, done, err;
    logic [1:0]   err_code;
    logic [15:0]  card_rca;
    logic         card_ccs;
    logic [31:0]  card_ocr;
    logic [127:0] card_cid, card_csd;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // scenario knobs
    int sc_if = 0;        // 0 echo, 1 wrong echo, 2 silent
    bit sc_vw_bad = 0;
    int sc_busy = 0;
    bit sc_ccs = 0;
    bit sc_r6_bad = 0;
    bit sc_r7_bad = 0;
    int sc_to_idx = -1;
    int busy_left = 0;

    logic [39:0] exp_q[$];
    int cd = 0;
    int pend_idx = 0;
    int last41 = -1000;
    bit after_retry = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_ident_seq #(.RSP_WAIT(T_WAIT), .MAX_POLLS(T_POLLS), .POLL_GAP(T_GAP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_kind(cmd_kind),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .card_rca(card_rca), .card_ccs(card_ccs), .card_ocr(card_ocr),
        .card_cid(card_cid), .card_csd(card_csd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input int idx, input logic [31:0] arg, input int kind);
        exp_q.push_back({kind[1:0], idx[5:0], arg});
    endtask

    function automatic logic [31:0] ready_ocr();
        return {1'b1, sc_ccs, 6'b0, 24'hFF8000};
    endfunction

    // Behavioural expectation of the command stream and the outcome.
    task automatic build(output int code);
        int tries;
        exp_q.delete();
        push(0, 0, 0);
        push(8, 32'h1AA, 1);
        code = 0;
        if (sc_if == 2) begin code = 1; return; end
        if (sc_if == 1) begin code = 2; return; end
        if (sc_vw_bad) tries = 1;
        else if (sc_busy >= T_POLLS) tries = T_POLLS;
        else tries = sc_busy + 1;
        for (int i = 0; i < tries; i++) begin
            push(55, 0, 1);
            push(41, 32'h50FF8000, 1);
        end
        if (sc_vw_bad) begin code = 2; return; end
        if (sc_busy >= T_POLLS) begin code = 3; return; end
        push(2, 0, 2);
        push(3, 0, 1);
        if (sc_r6_bad) begin code = 3; return; end
        push(9, {RCA, 16'h0}, 2);
        if (sc_to_idx == 9) begin code = 3; return; end
        push(7, {RCA, 16'h0}, 1);
        if (sc_r7_bad) begin code = 3; return; end
        if (!sc_ccs) push(16, 512, 1);
        push(55, {RCA, 16'h0}, 1);
        push(6, 2, 1);
    endtask

    function automatic logic [127:0] answer(input int idx);
        case (idx)
            8:  return (sc_if == 1) ? 128'h1AB : 128'h1AA;
            55: return 128'h0000_0120;
            41: begin
                if (sc_vw_bad) return 128'h00FF_0000;
                if (busy_left > 0) begin busy_left--; return 128'h00FF_8000; end
                return {96'h0, ready_ocr()};
            end
            2:  return CID;
            3:  return {96'h0, RCA, (sc_r6_bad ? 16'h8500 : 16'h0500)};
            9:  return CSD;
            7:  return sc_r7_bad ? 128'h0040_0700 : 128'h0000_0700;
            default: return 128'h0000_0900;
        endcase
    endfunction

    // Card model and command-stream comparison, evaluated at every falling edge.
    always @(negedge clk) begin
        cyc++;
        rsp_valid = 1'b0;
        rsp_timeout = 1'b0;
        if (rst_n) begin
            checks++;
            if (done && err) begin
                failures++;
                $display("FAIL R11 done and err both set actual=11 expected=not both");
            end
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    if (pend_idx == 8 && sc_if == 2) begin
                    end else if (pend_idx == sc_to_idx) begin
                        rsp_timeout = 1'b1;
                    end else begin
                        rsp_data = answer(pend_idx);
                        rsp_valid = 1'b1;
                        if (pend_idx == 41) begin
                            last41 = cyc;
                            after_retry = !rsp_data[31];
                        end
                    end
                end
            end
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R1", "unexpected command", {cmd_kind, cmd_index, cmd_arg}, 0);
                end else begin
                    logic [39:0] e;
                    e = exp_q.pop_front();
                    chk({cmd_kind, cmd_index, cmd_arg} == e, "R1/R8", "command kind/index/arg",
                        {cmd_kind, cmd_index, cmd_arg}, e);
                end
                if (cmd_index == 55 && after_retry) begin
                    chk(cyc - last41 >= T_GAP + 1, "R6", "poll gap cycles",
                        cyc - last41, T_GAP + 1);
                    after_retry = 0;
                end
                if (cmd_kind != 0) begin
                    pend_idx = cmd_index;
                    cd = 2;
                end
            end
        end
    end

    task automatic run(input string req, input bit poke);
        int code;
        int n;
        busy_left = sc_busy;
        after_retry = 0;
        build(code);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !err && busy, "R11", "start clears status", {done, err, busy}, 3'b001);
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!(done || err) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 3000, req, "sequence finished", n, 0);
        chk(done == (code == 0) && err == (code != 0), req, "done/err outcome",
            {done, err}, {code == 0, code != 0});
        chk(err_code == code[1:0], req, "err_code", err_code, code);
        chk(exp_q.size() == 0, req, "all expected commands issued", exp_q.size(), 0);
        repeat (5) @(negedge clk);
        chk(done == (code == 0) && err == (code != 0), "R11", "status held",
            {done, err}, {code == 0, code != 0});
        sc_if = 0; sc_vw_bad = 0; sc_busy = 0; sc_ccs = 0;
        sc_r6_bad = 0; sc_r7_bad = 0; sc_to_idx = -1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid, "R13", "reset state",
            {busy, done, err, cmd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid, "R13", "idle after reset",
            {busy, done, err, cmd_valid}, 0);

        // R1 R7 R8 R12: standard-capacity card, two busy polls
        sc_busy = 2; sc_ccs = 0;
        run("R1", 0);
        chk(card_rca == RCA, "R8", "card_rca", card_rca, RCA);
        chk(card_ccs == 1'b0, "R7", "card_ccs sdsc", card_ccs, 0);
        chk(card_cid == CID, "R12", "card_cid", card_cid, CID);
        chk(card_csd == CSD, "R12", "card_csd", card_csd, CSD);
        chk(card_ocr == 32'h80FF_8000, "R12", "card_ocr", card_ocr, 32'h80FF_8000);

        // R7: high-capacity card skips CMD16; R11 start poke while busy
        sc_ccs = 1;
        run("R7", 1);
        chk(card_ccs == 1'b1, "R7", "card_ccs sdhc", card_ccs, 1);
        chk(card_ocr == 32'hC0FF_8000, "R12", "card_ocr sdhc", card_ocr, 32'hC0FF_8000);

        sc_if = 2;     run("R2", 0);
        sc_if = 1;     run("R3", 0);
        sc_vw_bad = 1; run("R4", 0);
        sc_busy = 99;  run("R5", 0);
        sc_busy = 4;   run("R5", 0);
        sc_r6_bad = 1; run("R9", 0);
        sc_r7_bad = 1; sc_ccs = 1; run("R9", 0);
        sc_to_idx = 9; run("R10", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule